// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block connects a synchronous host request port to the asynchronous pins of a 128K x 16 pseudo-static RAM. The host presents a word address, a read/write flag, two byte-lane enables and write data under a valid/ready handshake. The controller runs the pins through a fixed order of phases: address setup, strobe access, release and recovery. For a read, it returns the captured word with a one-cycle valid pulse.

Every phase length is a parameter counted in clock cycles. The integrator picks the counts by dividing each nanosecond minimum of the chosen speed grade by the clock period and rounding up. Reads are chip-enable controlled: the address is stable before chip enable falls. Writes are ended by chip enable, write enable and the byte enables rising on the same edge. Write data stays driven for the whole release phase after that edge. The data bus is split into an output word, an input word and a drive enable, so the pad ring can build the tristate buffer.

Top module: `psram_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. For a request with at least one lane, `req_ready` stays low for SETUP+ACCESS+RELEASE+RECOVER cycles, where ACCESS is RD_CYC for a read and WR_CYC for a write.
- R2: From the cycle after acceptance, `mem_addr` carries the accepted address and does not change until the next acceptance. Chip enable falls only after SETUP_CYC cycles of address setup.
- R3: A read holds `mem_ce_n` and `mem_oe_n` low, with `mem_we_n` high, for exactly RD_CYC cycles. During that window, `mem_lb_n` is low when `req_be[0]` was set and `mem_ub_n` is low when `req_be[1]` was set.
- R4: Read data is sampled on the last access clock, before the strobes rise. `rd_valid` then pulses for one cycle. `rd_data[7:0]` carries the lower lane when `req_be[0]` was set and `rd_data[15:8]` carries the upper lane when `req_be[1]` was set. Lanes that were not enabled read as zero.
- R5: A write holds `mem_ce_n`, `mem_we_n` and the enabled byte strobes low, with `mem_oe_n` high, for exactly WR_CYC cycles. All of them rise on the same edge.
- R6: For a write, `mem_dq_oe` is high from the cycle after acceptance to the end of the release phase, and `mem_dq_o` holds the accepted write data throughout. `mem_dq_oe` is never high during a read, and never while `mem_oe_n` is low.
- R7: After release, all strobes stay high for RECOVER_CYC cycles before `req_ready` returns.
- R8: A request with `req_be` equal to zero never lowers any strobe, and `req_ready` returns after one cycle. For such a read, `rd_valid` pulses in the cycle after acceptance with `rd_data` equal to zero.
- R9: After reset, every strobe is high, `mem_dq_oe` and `rd_valid` are low and `req_ready` is high.
- R10: Changes to the request fields while the controller is busy and `req_valid` is low have no effect on the pins, the returned data or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 17 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_i | input | 16 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The bench builds the controller with SETUP_CYC=2, RD_CYC=4, WR_CYC=3, RELEASE_CYC=1 and RECOVER_CYC=2. Because reads and writes get different access lengths, an access length applied to the wrong operation shows up. RELEASE_CYC=1 puts the data hold after the write edge at its shortest, so a hold lost by even one cycle is visible. A behavioural memory on the pins stores only what the strobes actually write. Reads of every lane pattern, empty requests and the lowest and highest addresses are then checked against a host-level shadow copy.

// File: rtl/psram_ctrl_pkg.sv
// Shared types for the pseudo-static RAM controller.
// Assumes: all modules of the controller import this package.
package psram_ctrl_pkg;

    // Phases of one memory cycle, in the order they occur.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_ACCESS  = 3'd2,
        PH_RELEASE = 3'd3,
        PH_RECOVER = 3'd4
    } phase_t;

    localparam int LANE_W = 8;

endpackage

// File: rtl/psram_seq.sv
// Phase sequencer: steps IDLE -> SETUP -> ACCESS -> RELEASE -> RECOVER -> IDLE.
// It spends a parameterised number of cycles in each phase.
// Assumes: every cycle count is at least 1. An empty request skips straight
// to a one-cycle RECOVER. op_write is the latched operation type.
module psram_seq
    import psram_ctrl_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int RD_CYC      = 11,
    parameter int WR_CYC      = 9,
    parameter int RELEASE_CYC = 1,
    parameter int RECOVER_CYC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  logic   empty,
    input  logic   op_write,
    output phase_t phase_q,
    output phase_t phase_d,
    output logic   last_access
);

    localparam int MAX_A   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_B   = (SETUP_CYC > RELEASE_CYC) ? SETUP_CYC : RELEASE_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > RECOVER_CYC) ? MAX_C : RECOVER_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero    = (cnt_q == '0);
    assign last_access = (phase_q == PH_ACCESS) && cnt_zero;

    // Next phase and remaining-cycle count.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
        case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    phase_d = empty ? PH_RECOVER : PH_SETUP;
                    cnt_d   = empty ? '0 : CNT_W'(SETUP_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    phase_d = PH_ACCESS;
                    cnt_d   = op_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
            end
            PH_ACCESS: begin
                if (cnt_zero) begin
                    phase_d = PH_RELEASE;
                    cnt_d   = CNT_W'(RELEASE_CYC - 1);
                end
            end
            PH_RELEASE: begin
                if (cnt_zero) begin
                    phase_d = PH_RECOVER;
                    cnt_d   = CNT_W'(RECOVER_CYC - 1);
                end
            end
            PH_RECOVER: begin
                if (cnt_zero) phase_d = PH_IDLE;
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase and counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/psram_pins.sv
// Pin driver and read-data capture. Every strobe is a flop computed from the
// next phase, so the pins change on the same edge as the phase and cannot glitch.
// Assumes: op_*_d is the request that applies from the next cycle onward.
module psram_pins
    import psram_ctrl_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_d,
    input  logic              op_write_d,
    input  logic [LANES-1:0]  op_be_d,
    input  logic [LANES-1:0]  op_be_q,
    input  logic              capture,
    input  logic              empty_read,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [LANES-1:0]  be_n,
    output logic              dq_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic              in_access;
    logic              drive_win;
    logic [DATA_W-1:0] lane_mask;

    assign in_access = (phase_d == PH_ACCESS);
    assign drive_win = (phase_d == PH_SETUP) || in_access || (phase_d == PH_RELEASE);

    // Expand the lane enables into a bit mask.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{op_be_q[g]}};
    end

    // Strobe and drive-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            be_n  <= '1;
            dq_oe <= 1'b0;
        end else begin
            ce_n  <= !in_access;
            oe_n  <= !(in_access && !op_write_d);
            we_n  <= !(in_access && op_write_d);
            be_n  <= in_access ? ~op_be_d : '1;
            dq_oe <= drive_win && op_write_d;
        end
    end

    // Read capture on the last access clock, and the zero reply to an empty read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture || empty_read;
            if (capture)         rd_data <= mem_dq_i & lane_mask;
            else if (empty_read) rd_data <= '0;
        end
    end

endmodule

// File: rtl/psram_ctrl.sv
// Pseudo-static RAM controller top. It latches each accepted request and holds
// it until the next acceptance, and it connects the sequencer to the pin driver.
// Assumes: DATA_W is a multiple of 8, lane 0 is the low byte and the top lane
// is the high byte.
module psram_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 16,
    parameter int SETUP_CYC   = 2,
    parameter int RD_CYC      = 11,
    parameter int WR_CYC      = 9,
    parameter int RELEASE_CYC = 1,
    parameter int RECOVER_CYC = 2,
    localparam int LANES      = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe
);

    phase_t            phase_q, phase_d;
    logic              accept, empty_in, last_access;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q, write_d;
    logic [LANES-1:0]  be_q, be_d, be_n;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign empty_in  = (req_be == '0);
    assign write_d   = accept ? req_write : write_q;
    assign be_d      = accept ? req_be    : be_q;

    // Request latch: loaded on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            be_q    <= req_be;
            wdata_q <= req_wdata;
        end
    end

    psram_seq #(
        .SETUP_CYC   (SETUP_CYC),
        .RD_CYC      (RD_CYC),
        .WR_CYC      (WR_CYC),
        .RELEASE_CYC (RELEASE_CYC),
        .RECOVER_CYC (RECOVER_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .empty       (empty_in),
        .op_write    (write_q),
        .phase_q     (phase_q),
        .phase_d     (phase_d),
        .last_access (last_access)
    );

    psram_pins #(
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_d    (phase_d),
        .op_write_d (write_d),
        .op_be_d    (be_d),
        .op_be_q    (be_q),
        .capture    (last_access && !write_q),
        .empty_read (accept && empty_in && !req_write),
        .mem_dq_i   (mem_dq_i),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .be_n       (be_n),
        .dq_oe      (mem_dq_oe),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign mem_lb_n = be_n[0];
    assign mem_ub_n = be_n[LANES-1];

endmodule

// File: rtl/psram_ctrl_chk.sv
// Protocol checker for psram_ctrl, attached with bind.
// Assumes: synchronous active-low reset, with the pins at their idle levels after it.
module psram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);

    assert_busy_while_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_read_excludes_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    assert_lanes_inside_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_ub_n && mem_lb_n));

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_wdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && mem_dq_oe));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_hold_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

endmodule

bind psram_ctrl psram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/psram_ctrl_bench.sv
// Bench: a behavioural pin-level memory plus a cycle-count reference model,
// compared with the controller on every falling clock edge.
module psram_ctrl_bench;

    localparam int AW = 17, DW = 16;
    localparam int TS = 2, TRD = 4, TWR = 3, TL = 1, TR = 2;
    localparam int NOPS = 300;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0, mem_addr;
    logic [1:0]    req_be = '0;
    logic [DW-1:0] req_wdata = '0, rd_data, mem_dq_o, mem_dq_i;
    logic          rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

    int compared = 0, mismatched = 0, cycles = 0;
    logic [15:0] pmem   [int];   // contents written through the pins
    logic [15:0] shadow [int];   // contents expected from host requests

    always #2.5 clk = ~clk;

    psram_ctrl #(.SETUP_CYC(TS), .RD_CYC(TRD), .WR_CYC(TWR),
                 .RELEASE_CYC(TL), .RECOVER_CYC(TR)) u_psram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe));

    function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int a);
        return m.exists(a) ? m[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] lmask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // Memory model: store on every clock of the write overlap.
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = rd_word(pmem, int'(mem_addr));
            if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
            pmem[int'(mem_addr)] = w;
        end
    end

    // Memory model: return data while a read is selected.
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            mem_dq_i <= rd_word(pmem, int'(mem_addr)) & lmask({!mem_ub_n, !mem_lb_n});
        end else begin
            mem_dq_i <= 16'hA5A5;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    always @(posedge clk) cycles++;

    // Reference model state.
    bit          busy = 0, pending = 0, c_we = 0, c_empty = 0;
    int          k = 0, c_tot = 0, c_ta = 0, nop = 0;
    logic [AW-1:0] c_addr = '0;
    logic [1:0]    c_be = '0;
    logic [15:0]   c_exp = '0;

    initial begin
        for (int i = 0; i < 3; i++) @(negedge clk);
        // R9: idle levels under reset.
        chk("R9 ready", req_ready, 1);
        chk("R9 strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b11111);
        chk("R9 dq_oe", mem_dq_oe, 0);
        chk("R9 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        while (nop < NOPS || busy || pending) begin
            @(negedge clk);
            if (cycles > 60000) begin
                mismatched++;
                $display("FAIL watchdog expired at cycle %0d", cycles);
                break;
            end
            if (pending) begin
                busy = 1; pending = 0; k = 1;
            end else if (busy) begin
                k++;
                if (k > c_tot) busy = 0;
            end
            begin
                bit acc, setup, rel, rv;
                acc   = busy && !c_empty && k > TS && k <= TS + c_ta;
                setup = busy && !c_empty && k >= 1 && k <= TS;
                rel   = busy && !c_empty && k > TS + c_ta && k <= TS + c_ta + TL;
                rv    = busy && !c_we && (c_empty ? (k == 1) : (k == TS + c_ta + 1));
                chk("R1 ready", req_ready, !busy);
                chk("R2 R3 R5 ce_n", mem_ce_n, !acc);
                chk("R3 oe_n", mem_oe_n, !(acc && !c_we));
                chk("R5 we_n", mem_we_n, !(acc && c_we));
                chk("R3 R5 lb_n", mem_lb_n, !(acc && c_be[0]));
                chk("R3 R5 ub_n", mem_ub_n, !(acc && c_be[1]));
                chk("R6 R7 dq_oe", mem_dq_oe, c_we && (setup || acc || rel));
                chk("R4 R8 rd_valid", rd_valid, rv);
                if (rv) chk("R4 R8 rd_data", rd_data, c_exp);
                if (busy && !c_empty) chk("R2 R10 addr", mem_addr, c_addr);
            end
            if (!busy && nop < NOPS) begin
                logic [AW-1:0] a;
                logic [15:0] d;
                logic [1:0] be;
                bit wr;
                a  = (($urandom % 6) == 0) ? AW'(17'h1FFFF) : AW'($urandom % 5);
                d  = 16'($urandom);
                be = 2'($urandom);
                wr = (nop < 12) ? 1'b1 : 1'($urandom);
                if (nop < 12) be = 2'b11;
                req_valid = 1; req_addr = a; req_write = wr; req_be = be; req_wdata = d;
                pending = 1;
                c_addr = a; c_we = wr; c_be = be; c_empty = (be == 2'b00);
                c_ta = wr ? TWR : TRD;
                c_tot = c_empty ? 1 : TS + c_ta + TL + TR;
                if (wr) begin
                    logic [15:0] w;
                    w = rd_word(shadow, int'(a));
                    if (be[0]) w[7:0]  = d[7:0];
                    if (be[1]) w[15:8] = d[15:8];
                    shadow[int'(a)] = w;
                end else begin
                    c_exp = rd_word(shadow, int'(a)) & lmask(be);
                end
                nop++;
            end else begin
                // R10: scramble the fields while busy, with valid low.
                req_valid = 0;
                req_addr  = AW'($urandom);
                req_wdata = 16'($urandom);
                req_be    = 2'($urandom);
                req_write = 1'($urandom);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule